// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block steps through every row address of a DRAM array and decides, row by row, whether the row needs a refresh command in the current pass. The decision depends on how long each row can hold its data. Weak rows, which keep data only 64 to 128 ms, are recorded in a small bit-array membership filter. Rows that keep data 128 to 256 ms are recorded in a second filter, four times larger. Every other row falls back to the 256 ms default. One full sweep over the rows is one 64 ms base period. A two-bit period counter chooses which groups are due in the current sweep.

Rows are entered into the filters through an insert port. There is no per-row table and no way to remove a row. A row that was inserted always probes as present. A row that was never inserted may also probe as present, and the only cost is an extra refresh. A separate probe port lets the surrounding logic query both filters at any time. Each refresh is offered on a valid/ready pair that carries the row address. The row counter moves on only when the refresh has been accepted, or when the row is not due in this sweep.

Top module: `retention_refresh_sched`

## Requirements
- R1: After reset both filters are empty, the sweep starts at row 0 in period 0, and `ref_valid` is 1 with `ref_row` = 0.
- R2: `probe_weak` and `probe_mid` reflect the filters in the same cycle as `probe_row`. While the filters are empty, every row probes as absent.
- R3: An insert takes effect at the next clock edge. A row that has been inserted probes as present in its filter from then on, and no filter bit is ever cleared.
- R4: `ins_mid` = 0 inserts into the weak (64 ms) filter and `ins_mid` = 1 inserts into the 128 ms filter. An insert into the weak filter leaves the 128 ms filter's answers unchanged.
- R5: Rows are visited in ascending order and wrap from 2^ROW_W-1 to 0. With `ref_ready` held at 1, one row is handled per cycle, so a sweep takes exactly 2^ROW_W cycles.
- R6: The 2-bit period counter advances by one each time a sweep completes. In a sweep with period 0, every row is refreshed.
- R7: A row that hits the weak filter is refreshed in every sweep.
- R8: A row that hits the 128 ms filter, and not the weak filter, is refreshed only in sweeps whose period is even (0 or 2).
- R9: While `ref_valid` is 1 and `ref_ready` is 0, the request stays valid and `ref_row` does not change.
- R10: A row that hits neither filter is refreshed only in period-0 sweeps, which is once every four sweeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert the row on `ins_row` this cycle |
| ins_mid | input | 1 | Target filter: 0 = weak (64 ms), 1 = 128 ms |
| ins_row | input | ROW_W | Row address to insert |
| probe_row | input | ROW_W | Row address to query |
| probe_weak | output | 1 | `probe_row` is present in the weak filter |
| probe_mid | output | 1 | `probe_row` is present in the 128 ms filter |
| ref_valid | output | 1 | A refresh request is pending for `ref_row` |
| ref_ready | input | 1 | The refresh request is accepted this cycle |
| ref_row | output | ROW_W | Row address to refresh |

## Verification
The probe outputs and the refresh decision are combinational from state. The bench therefore drives inputs on the falling edge and samples one time unit later, within the same cycle. An insert becomes visible at the next rising edge, so a probe is never checked before the cycle after the insert. With `ref_ready` held high, the row under decision in bench cycle c of the sweep phase is c mod 64, in period (c/64) mod 4. Before the sweeps begin, the bench reads each row's membership through the probe port. For each cycle it then predicts `ref_valid` from that membership and the period, and this check never depends on the hash.

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched #(
  parameter int ROW_W     = 6,
  parameter int WEAK_BITS = 32,
  parameter int MID_BITS  = 128,
  parameter int WEAK_K    = 10,
  parameter int MID_K     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic             ins_mid,
  input  logic [ROW_W-1:0] ins_row,
  input  logic [ROW_W-1:0] probe_row,
  output logic             probe_weak,
  output logic             probe_mid,
  output logic             ref_valid,
  input  logic             ref_ready,
  output logic [ROW_W-1:0] ref_row
);

  localparam int WI = $clog2(WEAK_BITS);
  localparam int MI = $clog2(MID_BITS);

  function automatic int hidx(input logic [ROW_W-1:0] r, input int k, input int iw);
    logic [31:0] c;
    logic [31:0] x;
    int o;
    c = 32'h9E3779B9 ^ (32'h85EBCA6B * 32'(k + 1));
    for (int b = 0; b < 32; b++)
      x[b] = r[(b + (b / ROW_W) * (k + 1) + k) % ROW_W] ^ c[b];
    o = 0;
    for (int b = 0; b < 32; b++)
      o = o ^ (int'(x[b]) << (b % iw));
    return o;
  endfunction

  function automatic logic [WEAK_BITS-1:0] weak_mask(input logic [ROW_W-1:0] r);
    logic [WEAK_BITS-1:0] m;
    m = '0;
    for (int k = 0; k < WEAK_K; k++) m[hidx(r, k, WI)] = 1'b1;
    return m;
  endfunction

  function automatic logic [MID_BITS-1:0] mid_mask(input logic [ROW_W-1:0] r);
    logic [MID_BITS-1:0] m;
    m = '0;
    for (int k = 0; k < MID_K; k++) m[hidx(r, k + WEAK_K, MI)] = 1'b1;
    return m;
  endfunction

  logic [WEAK_BITS-1:0] weak_f;
  logic [MID_BITS-1:0]  mid_f;
  logic [ROW_W-1:0]     row_q;
  logic [1:0]           per_q;
  logic                 w_hit, m_hit, advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      weak_f <= '0;
      mid_f  <= '0;
    end else if (ins_valid) begin
      if (ins_mid) mid_f  <= mid_f  | mid_mask(ins_row);
      else         weak_f <= weak_f | weak_mask(ins_row);
    end
  end

  assign probe_weak = (weak_f & weak_mask(probe_row)) == weak_mask(probe_row);
  assign probe_mid  = (mid_f  & mid_mask(probe_row))  == mid_mask(probe_row);

  assign w_hit     = (weak_f & weak_mask(row_q)) == weak_mask(row_q);
  assign m_hit     = (mid_f  & mid_mask(row_q))  == mid_mask(row_q);
  assign ref_valid = w_hit | (m_hit & ~per_q[0]) | (per_q == 2'd0);
  assign ref_row   = row_q;
  assign advance   = ~ref_valid | ref_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      per_q <= '0;
    end else if (advance) begin
      row_q <= row_q + 1'b1;
      if (&row_q) per_q <= per_q + 2'd1;
    end
  end

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready |=> ref_valid && $stable(ref_row));

  a_r5_next_row: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_valid || ref_ready) |=> ref_row == ROW_W'($past(ref_row) + 1'b1));

  a_r3_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((weak_f & $past(weak_f)) == $past(weak_f)) && ((mid_f & $past(mid_f)) == $past(mid_f)));

  a_r3_weak_insert_hits: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_mid |=> (weak_f & weak_mask($past(ins_row))) == weak_mask($past(ins_row)));

  a_r4_mid_insert_hits: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_mid |=> (mid_f & mid_mask($past(ins_row))) == mid_mask($past(ins_row)));

endmodule

// File: tb/test_retention_refresh_sched.sv
module test_retention_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 6;
  localparam int ROWS = 1 << ROW_W;

  logic clk = 0, rst_n = 0, ins_valid = 0, ins_mid = 0, ref_ready = 0;
  logic [ROW_W-1:0] ins_row = '0, probe_row = '0, ref_row;
  logic probe_weak, probe_mid, ref_valid;
  int checks = 0, fails = 0;
  bit wk [ROWS];
  bit md [ROWS];

  retention_refresh_sched #(.ROW_W(ROW_W)) i_retention_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_mid(ins_mid),
    .ins_row(ins_row), .probe_row(probe_row), .probe_weak(probe_weak),
    .probe_mid(probe_mid), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_row(ref_row));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic insert(input int r, input bit mid);
    @(negedge clk); ins_valid = 1; ins_mid = mid; ins_row = ROW_W'(r);
    @(negedge clk); ins_valid = 0;
  endtask

  task automatic probe(input int r);
    probe_row = ROW_W'(r); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(ref_valid == 1, "R1 valid after reset", ref_valid, 1);
    chk(ref_row == 0, "R1 row after reset", ref_row, 0);
    for (int r = 0; r < ROWS; r++) begin
      probe(r);
      chk(!probe_weak && !probe_mid, "R2 empty filters miss", {probe_weak, probe_mid}, 0);
    end
    insert(3, 1); insert(40, 1);
    #1;
    probe(3);  chk(probe_mid == 1, "R3 mid row 3 hits", probe_mid, 1);
    probe(40); chk(probe_mid == 1, "R3 mid row 40 hits", probe_mid, 1);
    for (int r = 0; r < ROWS; r++) begin
      probe(r);
      chk(probe_weak == 0, "R4 weak filter untouched by mid insert", probe_weak, 0);
    end
    chk(ref_valid == 1 && ref_row == 0, "R9 stalled at row 0", ref_row, 0);
    insert(17, 0); insert(50, 0);
    #1;
    probe(17); chk(probe_weak == 1, "R3 weak row 17 hits", probe_weak, 1);
    probe(50); chk(probe_weak == 1, "R3 weak row 50 hits", probe_weak, 1);
    probe(3);  chk(probe_mid == 1, "R3 mid row 3 still hits", probe_mid, 1);
    probe(40); chk(probe_mid == 1, "R3 mid row 40 still hits", probe_mid, 1);
    begin
      int nd;
      nd = 0;
      for (int r = 0; r < ROWS; r++) begin
        probe(r);
        wk[r] = probe_weak; md[r] = probe_mid;
        if (!probe_weak && !probe_mid) nd++;
      end
      chk(nd > 0, "R10 some rows in default bin", nd, 1);
    end
    chk(ref_valid == 1 && ref_row == 0, "R9 still stalled at row 0", ref_row, 0);

    for (int c = 0; c < 8 * ROWS; c++) begin
      int r, p;
      bit exp;
      string tag;
      @(negedge clk); ref_ready = 1; #1;
      r = c % ROWS; p = (c / ROWS) % 4;
      exp = wk[r] || (md[r] && (p % 2 == 0)) || (p == 0);
      if (p == 0) tag = "R6 period-0 refresh";
      else if (wk[r]) tag = "R7 weak row refresh";
      else if (md[r]) tag = "R8 mid row refresh";
      else tag = "R10 default row skip";
      chk(ref_valid == exp, tag, ref_valid, exp);
      if (ref_valid) chk(ref_row == ROW_W'(r), "R5 row order", ref_row, r);
    end

    for (int c = 0; c < 5; c++) begin
      @(negedge clk); ref_ready = 1;
    end
    @(negedge clk); ref_ready = 0; #1;
    chk(ref_valid == 1 && ref_row == 5, "R9 request at row 5", ref_row, 5);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(ref_valid == 1, "R9 valid held", ref_valid, 1);
      chk(ref_row == 5, "R9 row held", ref_row, 5);
    end
    @(negedge clk); ref_ready = 1; #1;
    chk(ref_row == 5, "R9 row 5 accepted", ref_row, 5);
    @(negedge clk); #1;
    chk(ref_row == 6, "R5 advance after accept", ref_row, 6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule